// File: doc/BRIEF.md
# Sticky Configuration Lock Register

This block holds one 32-bit configuration word whose write behaviour depends on its own current contents. The word carries a one-way disable flag, a byte of lock-control bits, a program-lock byte and a read-lock byte. The disable flag and the lock-control bits can be set by software but never cleared, except by reset. Each lock-control bit, once set, freezes one bit in each of the two lower lock bytes. This gives a two-level hierarchy: the lower bytes are ordinary writable settings until a lock-control bit freezes part of them.

The surrounding logic writes the word with a single-cycle strobe and full 32-bit data. It reads the held value at any time from a read-data output that has no side effects. The block does not act on the lock bytes itself. It only computes and holds the word.

Top module: `cfg_lock_reg`

## Requirements
- R1: A synchronous reset, sampled high on a rising clock edge, loads the word 0x20000000, which clears every sticky bit.
- R2: Bit 31 is the disable flag. A write with bit 31 = 1 sets it. No later write clears it.
- R3: Bits [23:16] are the lock-control bits. A write with a 1 in any of them sets that bit. No later write clears a set lock-control bit.
- R4: While lock-control bit 16+k is set, bit 8+k (program-lock byte, bits [15:8]) and bit k (read-lock byte, bits [7:0]) keep their current values on every write, whatever the written data holds.
- R5: Protection is decided from the word as it stood before the write. A write that sets lock-control bit 16+k still loads bits 8+k and k from its own data. The protection applies from the next write on.
- R6: Unprotected bits in [15:0] take the written data, so a write can both set and clear them.
- R7: Bits [30:24] are ordinary bits that take the written data. Bit 29, set by reset, can be cleared by a write.
- R8: Without a write strobe the word holds its value. rd_data always shows the held word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 32 | Data offered with the write strobe |
| rd_data | output | 32 | Currently held configuration word |

## Verification
The hardest case to reach is a protected bit that differs from the written data in both directions. The bench has to show that a frozen 1 survives a write of 0 and that a frozen 0 survives a write of 1. To get there, it first loads the lock bytes with a mix of ones and zeros while no lock is set. It then sets a lock-control bit in a separate write, and after that writes the complement of the frozen pattern. A further write sets a lock-control bit and new lock-byte data together, which shows that the same write still loads that data.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 4 * LANE_W;
  localparam int DIS_POS = WORD_W - 1;
  localparam int LK_LO = 2 * LANE_W;

  typedef logic [WORD_W-1:0] cfg_word_t;

  // Bits that can only be set: disable flag plus the lock-control byte.
  function automatic cfg_word_t sticky_mask();
    cfg_word_t m;
    m = '0;
    m[DIS_POS] = 1'b1;
    for (int i = 0; i < LANE_W; i++) m[LK_LO + i] = 1'b1;
    return m;
  endfunction

  // Merge rule: sticky bits accumulate, protected bits hold, the rest follow data.
  function automatic cfg_word_t merge_word(cfg_word_t cur, cfg_word_t wd, cfg_word_t prot);
    cfg_word_t stk;
    stk = sticky_mask();
    return (cur & stk) | (wd & stk) | (cur & prot) | (wd & ~prot & ~stk);
  endfunction
endpackage

// File: rtl/cfg_lock_mask_gen.sv
module cfg_lock_mask_gen
  import cfg_lock_pkg::*;
(
  input  cfg_word_t cur_word,
  output cfg_word_t protect_mask
);
  // Each lock-control bit fans out to one bit in each of the two lower bytes.
  for (genvar k = 0; k < LANE_W; k++) begin : g_lane
    assign protect_mask[k]          = cur_word[LK_LO + k];
    assign protect_mask[LANE_W + k] = cur_word[LK_LO + k];
  end
  assign protect_mask[WORD_W-1:LK_LO] = '0;
endmodule

// File: rtl/cfg_lock_next.sv
module cfg_lock_next
  import cfg_lock_pkg::*;
(
  input  cfg_word_t cur_word,
  input  cfg_word_t wr_word,
  input  cfg_word_t protect_mask,
  output cfg_word_t next_word
);
  assign next_word = merge_word(cur_word, wr_word, protect_mask);
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg
  import cfg_lock_pkg::*;
#(
  parameter logic [31:0] RST_VAL = 32'h2000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);
  localparam cfg_word_t STICKY = sticky_mask();

  cfg_word_t word_q;
  cfg_word_t protect_mask;
  cfg_word_t next_word;
  logic [LANE_W-1:0] lock_ctl;

  assign lock_ctl = word_q[LK_LO +: LANE_W];

  cfg_lock_mask_gen u_mask (
    .cur_word     (word_q),
    .protect_mask (protect_mask)
  );

  cfg_lock_next u_next (
    .cur_word     (word_q),
    .wr_word      (wr_data),
    .protect_mask (protect_mask),
    .next_word    (next_word)
  );

  always_ff @(posedge clk) begin
    if (rst)        word_q <= RST_VAL;
    else if (wr_en) word_q <= next_word;
  end

  assign rd_data = word_q;

  AST_RESET_VALUE: assert property (@(posedge clk) rst |=> rd_data == RST_VAL); // R1
  AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
    rd_data[DIS_POS] |=> rd_data[DIS_POS]); // R2
  AST_LOCKCTL_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rd_data[LK_LO +: LANE_W] & $past(lock_ctl)) == $past(lock_ctl))); // R3
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((rd_data & $past(wr_data) & STICKY) == ($past(wr_data) & STICKY))); // R2
  AST_PROTECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((rd_data ^ $past(rd_data)) & $past(protect_mask)) == '0)); // R4
  AST_FREE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (((rd_data ^ $past(wr_data)) & ~$past(protect_mask) & ~STICKY) == '0)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data)); // R8
endmodule

// File: tb/cfg_lock_reg_tb.sv
module cfg_lock_reg_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  int checks = 0;
  int errors = 0;
  logic [31:0] model = 32'h2000_0000;

  always #2 clk = ~clk;

  cfg_lock_reg u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  // Bench-side rule, stated per bit from the requirements.
  function automatic logic [31:0] predict(logic [31:0] cur, logic [31:0] wd);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) begin
      if (b == 31 || (b >= 16 && b <= 23)) r[b] = cur[b] | wd[b];
      else if (b < 16 && cur[16 + (b % 8)]) r[b] = cur[b];
      else r[b] = wd[b];
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%08h expected=%08h", req, rd_data, exp);
    end
  endtask

  task automatic do_write(logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
    model = predict(model, d);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model = 32'h2000_0000;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", 32'h2000_0000);
  endtask

  task automatic t_plain();
    do_write(32'h0000_5A3C); check("R7", 32'h0000_5A3C); check("R7", model);
    do_write(32'h4000_0000); check("R6", 32'h4000_0000);
  endtask

  task automatic t_disable();
    do_write(32'h8000_0000); check("R2", 32'h8000_0000);
    do_write(32'h0000_0000); check("R2", 32'h8000_0000);
  endtask

  task automatic t_lock_levels();
    do_write(32'h0001_0101); check("R5", 32'h8001_0101);
    do_write(32'h0000_0000); check("R3", 32'h8001_0101);
    do_write(32'h0000_FEFE); check("R4", 32'h8001_FFFF);
    do_write(32'h0000_0000); check("R6", 32'h8001_0101);
    do_write(32'h0002_0000); check("R5", 32'h8003_0101);
    do_write(32'h0000_0202); check("R4", 32'h8003_0101); check("R4", model);
  endtask

  task automatic t_idle();
    repeat (5) @(negedge clk);
    check("R8", 32'h8003_0101);
  endtask

  task automatic t_all_locks();
    do_reset();
    check("R1", 32'h2000_0000);
    do_write(32'h00FF_A55A); check("R5", 32'h00FF_A55A);
    do_write(32'hFFFF_FFFF); check("R4", 32'hFFFF_A55A);
    do_write(32'h0000_0000); check("R3", 32'h80FF_A55A); check("R2", model);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: rd_data=%08h expected=done", rd_data);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1", 32'h2000_0000);
    t_plain();
    t_disable();
    t_lock_levels();
    t_idle();
    t_reset();
    t_all_locks();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule